// File: doc/BRIEF.md
# Incremental Position Catch-Up Tracker

This block turns an absolute angle word from a sensor front end into an incremental position stream. After reset the tracked position sits at zero and the block reports that it is not ready. Once the angle input has stayed valid for a settling interval, it walks the tracked position to the absolute angle one count at a time. Every count on the way comes out as a one-cycle up or down strobe, so an external counter that follows the strobes ends up holding the absolute angle.

During catch-up the count direction depends on which half-turn the target is in. A target in the lower half is reached by counting up from zero. A target in the upper half is reached by counting down from zero through the wrap at full scale. Once the target is reached, the not-ready flag clears. From then on the block follows later angle changes, moving at most one step per step period along the shorter way around the circle. Two resolutions can be selected: the full word, or a coarser mode that uses only the top six bits. A zero indication is high whenever the tracked position is zero.

Step period and settling interval are parameters in clock cycles. With a 4 µs period and a 100 µs settle at full 8-bit resolution, the worst-case time to a valid position is 100 µs + 128 × 4 µs = 612 µs.

Top module: `angle_catchup_tracker`

## Requirements
- R1: While reset is held and just after it is released, track_pos is 0, both strobes are low, not_ready is high and zero_idx is high.
- R2: No step occurs until angle_ok has been high for SETTLE_CYC consecutive clock cycles. A cycle with angle_ok low restarts that count. The position stays 0 throughout.
- R3: In catch-up, a target below half scale is reached by counting up from 0 only. A target at or above half scale is reached by counting down from 0 only.
- R4: Each strobe marks a change of track_pos by exactly one count in its direction, so no count is skipped. The first step comes STEP_CYC cycles after settling completes, and the steps after it are STEP_CYC cycles apart.
- R5: not_ready falls one cycle after the final catch-up step and then stays low until reset. With angle_ok high from reset release, this is SETTLE_CYC + 3 + STEP_CYC × N cycles after release, where N is the number of catch-up steps.
- R6: After catch-up, on each step period the position moves one count toward the current target. Let d = (target − position) mod full scale. The block counts up when 0 < d ≤ half scale and counts down when d > half scale.
- R7: Counting wraps at full scale: one up step from the largest code gives 0, and one down step from 0 gives the largest code.
- R8: With res_sel = 1, the target is abs_angle[7:2], full scale is 64, and track_pos[7:6] stays 0. With res_sel = 0, the target is abs_angle and full scale is 256.
- R9: res_sel is sampled only while settling. Changes after settling ends have no effect on target, scale or wrap.
- R10: zero_idx is high exactly when track_pos is 0.
- R11: step_up and step_dn are never high in the same cycle.
- R12: After catch-up, while angle_ok is low, no step is taken and not_ready stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| abs_angle | input | 8 | Absolute angle word from the sensor front end |
| angle_ok | input | 1 | Angle word valid and settled |
| res_sel | input | 1 | 0: 8-bit resolution, 1: 6-bit resolution |
| step_up | output | 1 | One-cycle strobe, tracked position went up by one |
| step_dn | output | 1 | One-cycle strobe, tracked position went down by one |
| track_pos | output | 8 | Tracked incremental position |
| zero_idx | output | 1 | High while the tracked position is zero |
| not_ready | output | 1 | High until catch-up has reached the absolute angle |

## Verification
The bench builds the block with STEP_CYC = 3 and SETTLE_CYC = 5 and keeps the 8-bit width. With these values even the worst-case 128-step catch-up finishes within a few hundred cycles, so the exact ready time can be compared against the formula. The short settle window also makes it cheap to drop angle_ok just before settling completes and observe the restart. Since every step costs only three cycles, one run can cover wrap in both directions, the shorter-path choice and the coarse mode.

// File: rtl/angle_trk_pkg.sv
package angle_trk_pkg;

  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_CATCH  = 2'd1,
    PH_TRACK  = 2'd2
  } trk_phase_e;

endpackage

// File: rtl/trk_rst_sync.sv
module trk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/trk_settle_timer.sv
module trk_settle_timer #(
  parameter int SETTLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ok,
  output logic done
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    done  = 1'b0;
    if (run && ok) begin
      if (cnt_q == LAST) done = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a dropped valid flag throws away the settle progress
  a_r2_restart_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ok) |=> (cnt_q == '0));

endmodule

// File: rtl/trk_step_pacer.sv
module trk_step_pacer #(
  parameter int STEP_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int TMR_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(STEP_CYC - 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    tick  = run && (tmr_q == LAST);
    tmr_d = tmr_q;
    if (!run)      tmr_d = '0;
    else if (tick) tmr_d = '0;
    else           tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  generate
    if (STEP_CYC > 1) begin : g_gap_chk
      // R4: step opportunities are never back to back
      a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/trk_step_dir.sv
module trk_step_dir #(
  parameter int POS_W = 8,
  parameter int LOW_W = 6
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] tgt,
  input  logic             res_lo,
  input  logic             catch_mode,
  output logic             at_tgt,
  output logic             want_up,
  output logic             want_dn
);

  localparam logic [POS_W-1:0] LOW_MASK  = POS_W'((1 << LOW_W) - 1);
  localparam logic [POS_W-1:0] FULL_HALF = POS_W'(1 << (POS_W - 1));
  localparam logic [POS_W-1:0] LOW_HALF  = POS_W'(1 << (LOW_W - 1));

  logic [POS_W-1:0] mask, half, diff;
  logic             tgt_upper;

  always_comb begin
    mask      = res_lo ? LOW_MASK : '1;
    half      = res_lo ? LOW_HALF : FULL_HALF;
    diff      = (tgt - pos) & mask;
    tgt_upper = res_lo ? tgt[LOW_W-1] : tgt[POS_W-1];
    at_tgt    = (diff == '0);
    if (catch_mode) begin
      want_up = !at_tgt && !tgt_upper;
      want_dn = !at_tgt &&  tgt_upper;
    end else begin
      want_up = !at_tgt && (diff <= half);
      want_dn = !at_tgt && (diff >  half);
    end
  end

endmodule

// File: rtl/angle_catchup_tracker.sv
module angle_catchup_tracker
  import angle_trk_pkg::*;
#(
  parameter int POS_W      = 8,
  parameter int LOW_W      = 6,
  parameter int STEP_CYC   = 400,
  parameter int SETTLE_CYC = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] abs_angle,
  input  logic             angle_ok,
  input  logic             res_sel,
  output logic             step_up,
  output logic             step_dn,
  output logic [POS_W-1:0] track_pos,
  output logic             zero_idx,
  output logic             not_ready
);

  localparam int               SHIFT    = POS_W - LOW_W;
  localparam logic [POS_W-1:0] LOW_MASK = POS_W'((1 << LOW_W) - 1);

  logic             srst_n;
  trk_phase_e       phase_q, phase_d;
  logic             res_q, res_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             up_q, up_d, dn_q, dn_d;
  logic [POS_W-1:0] tgt, mask;
  logic             settle_done, tick;
  logic             at_tgt, want_up, want_dn;
  logic             move_up, move_dn;

  trk_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  trk_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (phase_q == PH_SETTLE),
    .ok    (angle_ok),
    .done  (settle_done)
  );

  trk_step_pacer #(.STEP_CYC(STEP_CYC)) i_pacer (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (phase_q != PH_SETTLE),
    .tick  (tick)
  );

  assign tgt  = res_q ? POS_W'(abs_angle >> SHIFT) : abs_angle;
  assign mask = res_q ? LOW_MASK : '1;

  trk_step_dir #(.POS_W(POS_W), .LOW_W(LOW_W)) i_dir (
    .pos        (pos_q),
    .tgt        (tgt),
    .res_lo     (res_q),
    .catch_mode (phase_q == PH_CATCH),
    .at_tgt     (at_tgt),
    .want_up    (want_up),
    .want_dn    (want_dn)
  );

  always_comb begin
    phase_d = phase_q;
    res_d   = res_q;
    move_up = 1'b0;
    move_dn = 1'b0;
    unique case (phase_q)
      PH_SETTLE: begin
        res_d = res_sel;
        if (settle_done) phase_d = PH_CATCH;
      end
      PH_CATCH: begin
        if (at_tgt) phase_d = PH_TRACK;
        else if (tick) begin
          move_up = want_up;
          move_dn = want_dn;
        end
      end
      PH_TRACK: begin
        if (tick && angle_ok) begin
          move_up = want_up;
          move_dn = want_dn;
        end
      end
      default: phase_d = PH_SETTLE;
    endcase
    up_d  = move_up;
    dn_d  = move_dn;
    pos_d = pos_q;
    if (move_up)      pos_d = (pos_q + 1'b1) & mask;
    else if (move_dn) pos_d = (pos_q - 1'b1) & mask;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= PH_SETTLE;
      res_q   <= 1'b0;
      pos_q   <= '0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      res_q   <= res_d;
      pos_q   <= pos_d;
      up_q    <= up_d;
      dn_q    <= dn_d;
    end
  end

  assign step_up   = up_q;
  assign step_dn   = dn_q;
  assign track_pos = pos_q;
  assign zero_idx  = (pos_q == '0);
  assign not_ready = (phase_q != PH_TRACK);

  // R11: one direction per strobe cycle
  a_r11_one_dir: assert property (@(posedge clk) disable iff (!srst_n)
    !(up_q && dn_q));

  // R4, R7: an up strobe means exactly one count up, modulo scale
  a_r4_up_moves_one: assert property (@(posedge clk) disable iff (!srst_n)
    up_q |-> (pos_q == (($past(pos_q) + 1'b1) & mask)));

  // R4, R7: a down strobe means exactly one count down, modulo scale
  a_r4_dn_moves_one: assert property (@(posedge clk) disable iff (!srst_n)
    dn_q |-> (pos_q == (($past(pos_q) - 1'b1) & mask)));

  // R5: once ready, the flag stays clear
  a_r5_ready_sticks: assert property (@(posedge clk) disable iff (!srst_n)
    !not_ready |=> !not_ready);

  // R12: no valid flag while tracking means no step
  a_r12_hold_no_ok: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == PH_TRACK && !angle_ok) |=> (!up_q && !dn_q));

  // R2: nothing moves while settling
  a_r2_quiet_settle: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == PH_SETTLE) |-> (pos_q == '0 && !up_q && !dn_q));

  // R8: coarse mode keeps the upper bits clear
  a_r8_low_range: assert property (@(posedge clk) disable iff (!srst_n)
    (res_q && phase_q != PH_SETTLE) |-> ((pos_q & ~LOW_MASK) == '0));

endmodule

// File: tb/test_angle_catchup_tracker.sv
module test_angle_catchup_tracker;

  localparam int PW  = 8;
  localparam int STP = 3;
  localparam int SET = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] abs_angle;
  logic          angle_ok, res_sel;
  logic          step_up, step_dn, zero_idx, not_ready;
  logic [PW-1:0] track_pos;

  always #5 clk = ~clk;

  angle_catchup_tracker #(.POS_W(PW), .LOW_W(6), .STEP_CYC(STP), .SETTLE_CYC(SET))
    i_angle_catchup_tracker (
      .clk(clk), .rst_n(rst_n), .abs_angle(abs_angle), .angle_ok(angle_ok),
      .res_sel(res_sel), .step_up(step_up), .step_dn(step_dn),
      .track_pos(track_pos), .zero_idx(zero_idx), .not_ready(not_ready));

  int n_run = 0, n_fail = 0;
  bit compare_on = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model: 0 settle, 1 catch-up, 2 tracking
  int m_ph, m_cnt, m_tmr, m_pos, m_res, m_rel;
  bit m_up, m_dn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_tmr = 0; m_pos = 0; m_res = 0;
      m_up = 0; m_dn = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      int scale, tg, d;
      bit tk;
      scale = m_res ? 64 : 256;
      tg    = m_res ? (int'(abs_angle) / 4) : int'(abs_angle);
      m_up = 0; m_dn = 0;
      if (m_ph == 0) begin
        m_res = res_sel;
        m_tmr = 0;
        if (!angle_ok) m_cnt = 0;
        else if (m_cnt == SET - 1) begin m_cnt = 0; m_ph = 1; end
        else m_cnt++;
      end else begin
        tk    = (m_tmr == STP - 1);
        m_tmr = tk ? 0 : m_tmr + 1;
        if (m_ph == 1) begin
          if (m_pos == tg) m_ph = 2;
          else if (tk) begin
            if (tg < scale / 2) m_up = 1; else m_dn = 1;
          end
        end else if (tk && angle_ok && m_pos != tg) begin
          d = (tg - m_pos + scale) % scale;
          if (d <= scale / 2) m_up = 1; else m_dn = 1;
        end
        if (m_up) m_pos = (m_pos + 1) % scale;
        if (m_dn) m_pos = (m_pos + scale - 1) % scale;
      end
    end
  end

  // per-cycle comparison and stimulus monitors
  int  ups, dns, maxpos, prevpos;
  bit  wrap_up, wrap_dn, both_seen;

  task automatic clear_mon();
    ups = 0; dns = 0; maxpos = 0; wrap_up = 0; wrap_dn = 0;
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      chk(int'(track_pos) == m_pos, "R6", "track_pos", int'(track_pos), m_pos);
      chk(step_up == m_up, "R4", "step_up", int'(step_up), int'(m_up));
      chk(step_dn == m_dn, "R4", "step_dn", int'(step_dn), int'(m_dn));
      chk(not_ready == (m_ph != 2), "R5", "not_ready", int'(not_ready), int'(m_ph != 2));
      chk(zero_idx == (m_pos == 0), "R10", "zero_idx", int'(zero_idx), int'(m_pos == 0));
      if (step_up) ups++;
      if (step_dn) dns++;
      if (step_up && step_dn) both_seen = 1;
      if (int'(track_pos) > maxpos) maxpos = int'(track_pos);
      if (prevpos == 255 && track_pos == 8'd0 && step_up) wrap_up = 1;
      if (prevpos == 63  && track_pos == 8'd0 && step_up) wrap_up = 1;
      if (prevpos == 0 && track_pos != 8'd0 && step_dn) wrap_dn = 1;
      prevpos = int'(track_pos);
    end
  end

  task automatic restart(input bit res, input logic [PW-1:0] ang);
    rst_n = 1'b0;
    res_sel = res; abs_angle = ang; angle_ok = 1'b1;
    repeat (2) @(negedge clk);
    clear_mon();
    prevpos = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (not_ready && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int cyc;
    rst_n = 1'b0; abs_angle = '0; angle_ok = 1'b0; res_sel = 1'b0;
    both_seen = 0; prevpos = 0;
    clear_mon();
    repeat (2) @(negedge clk);
    compare_on = 1;

    // R1: reset state
    chk(track_pos == 0, "R1", "track_pos", int'(track_pos), 0);
    chk(!step_up && !step_dn, "R1", "strobes", int'(step_up) + int'(step_dn), 0);
    chk(not_ready == 1, "R1", "not_ready", int'(not_ready), 1);
    chk(zero_idx == 1, "R1", "zero_idx", int'(zero_idx), 1);

    // R3, R5: lower-half target, counts up
    restart(1'b0, 8'd40);
    wait_ready(cyc);
    chk(cyc == SET + 3 + STP * 40, "R5", "ready cycles", cyc, SET + 3 + STP * 40);
    chk(ups == 40 && dns == 0, "R3", "up steps to 40", ups * 1000 + dns, 40000);
    chk(track_pos == 8'd40, "R4", "final pos", int'(track_pos), 40);

    // R3, R7: upper-half target, counts down through wrap
    restart(1'b0, 8'd200);
    wait_ready(cyc);
    chk(dns == 56 && ups == 0, "R3", "down steps to 200", dns * 1000 + ups, 56000);
    chk(wrap_dn, "R7", "down wrap 0 to 255", int'(wrap_dn), 1);

    // R6, R7: tracking takes the short way across zero
    clear_mon();
    abs_angle = 8'd10;
    repeat (66 * STP + 10) @(negedge clk);
    chk(ups == 66 && dns == 0, "R6", "short path ups", ups * 1000 + dns, 66000);
    chk(wrap_up, "R7", "up wrap 255 to 0", int'(wrap_up), 1);
    chk(track_pos == 8'd10, "R6", "tracked pos", int'(track_pos), 10);

    // R12: invalid angle while tracking holds position
    clear_mon();
    angle_ok = 1'b0; abs_angle = 8'd100;
    repeat (30) @(negedge clk);
    chk(ups + dns == 0, "R12", "steps while invalid", ups + dns, 0);
    chk(track_pos == 8'd10 && !not_ready, "R12", "held pos", int'(track_pos), 10);
    angle_ok = 1'b1;
    repeat (90 * STP + 10) @(negedge clk);
    chk(track_pos == 8'd100, "R6", "resumed pos", int'(track_pos), 100);

    // R5, R3: worst case, exactly half scale
    restart(1'b0, 8'd128);
    wait_ready(cyc);
    chk(cyc == SET + 3 + STP * 128, "R5", "worst ready cycles", cyc, SET + 3 + STP * 128);
    chk(dns == 128 && ups == 0, "R3", "down steps to 128", dns * 1000 + ups, 128000);

    // R2: a drop of the valid flag restarts settling
    restart(1'b0, 8'd5);
    repeat (SET + 1) @(negedge clk);
    angle_ok = 1'b0;
    @(negedge clk);
    angle_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk(not_ready && track_pos == 0 && ups == 0, "R2", "still settling", int'(track_pos) + ups, 0);
    wait_ready(cyc);
    chk(ups == 5, "R2", "steps after settle", ups, 5);

    // R8: coarse mode
    restart(1'b1, 8'hF0);
    wait_ready(cyc);
    chk(dns == 4 && ups == 0, "R8", "coarse down steps", dns * 1000 + ups, 4000);
    chk(track_pos == 8'd60, "R8", "coarse pos", int'(track_pos), 60);

    // R9: late resolution change ignored
    clear_mon();
    res_sel = 1'b0; abs_angle = 8'h08;
    repeat (6 * STP + 10) @(negedge clk);
    chk(ups == 6 && dns == 0, "R9", "coarse short path", ups * 1000 + dns, 6000);
    chk(track_pos == 8'd2, "R9", "coarse tracked pos", int'(track_pos), 2);
    chk(maxpos <= 63, "R8", "coarse max pos", maxpos, 63);

    chk(!both_seen, "R11", "both strobes", int'(both_seen), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    chk(1'b0, "R5", "watchdog expired", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule